// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a synthesizable model of a small synchronous burst memory. All inputs are sampled on the rising clock edge. A controller address strobe, qualified by an active-low chip select, either starts a new access at an external address or deselects the part. Once an access has started, an advance input steps a two-bit burst counter through four beats. The burst order is set by a static order-select input: linear or interleaved.

The data path is organised as byte lanes. Each lane carries eight data bits and one parity bit, and the parity bit is stored and returned with its byte. Each lane has its own active-low write enable. Read data passes through one output register, so it appears one cycle after the address is taken, and a valid flag marks it.

An asynchronous, active-high sleep input freezes the part at once. While sleep is high, the array keeps its contents and all other inputs are ignored. When sleep is released, the part starts again deselected.

Top module: `srb_sram`

## Requirements
- R1: A cycle with `strobe_n`=0 and `sel_n`=0 loads `addr` as the new burst start and accesses `addr` on that edge. This holds even when a burst is in progress, which is then abandoned.
- R2: A read access (every `lane_we_n` bit high) drives `rvalid`=1 and `rdata` = stored word after the same clock edge that sampled the access. The stored word includes the parity bits.
- R3: A cycle with `strobe_n`=0 and `sel_n`=1 deselects the part, and `rvalid` is 0 after that edge. Advance requests are then ignored until the next selected strobe.
- R4: With `order_ilv`=0, beat k of a burst accesses the start address with its two low bits replaced by (start low bits + k) mod 4. The upper bits are unchanged.
- R5: With `order_ilv`=1, beat k accesses the start address with its two low bits replaced by (start low bits XOR k). The upper bits are unchanged.
- R6: Sleep acts asynchronously. While `sleep`=1, `rvalid` is 0, `rdata` is 0 and no input has any effect. The array contents are kept, and after release the part is deselected.
- R7: Lane i occupies `wdata`/`rdata` bits [9i+8:9i], and bit 9i+8 is that lane's parity. An access with any `lane_we_n` bit low is a write: it stores only the lanes whose bit is 0, leaves the other lanes unchanged, and gives `rvalid`=0.
- R8: While a burst is active and `strobe_n`=1, `adv_n`=0 steps to the next beat and performs an access. `adv_n`=1 performs no access, holds the beat, and gives `rvalid`=0.
- R9: The advance that follows the fourth beat returns to the start address (beat 0), and the burst keeps cycling.
- R10: After reset, `rvalid` and `rdata` are 0 and the part is deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sleep | input | 1 | Asynchronous sleep, active high |
| strobe_n | input | 1 | Controller address strobe, active low |
| sel_n | input | 1 | Chip select, active low, qualified by the strobe |
| adv_n | input | 1 | Burst advance, active low |
| order_ilv | input | 1 | Burst order: 0 linear, 1 interleaved (static) |
| lane_we_n | input | LANES | Per-lane write enables, active low |
| addr | input | AW | External word address |
| wdata | input | 9*LANES | Write data, 8 data bits and 1 parity bit per lane |
| rdata | output | 9*LANES | Registered read data |
| rvalid | output | 1 | rdata holds a read result |

## Verification
The hardest state to reach is sleep asserted between clock edges in the middle of an active burst, with strobes and writes applied while the part sleeps. The bench raises sleep half a cycle into a burst and checks the outputs before the next edge. It then issues strobes, advances and writes during sleep and checks that none of them had an effect. After release, it checks that advances do nothing until a fresh strobe, and it reads back the words that the ignored writes targeted. Wrap-around and burst abort are reached with bursts of five or more advances and with strobes issued in mid-burst.

// File: rtl/srb_pkg.sv
package srb_pkg;
    localparam int BEAT_BITS = 2;
    localparam int LANE_BITS = 9;
endpackage

// File: rtl/srb_burst_seq.sv
module srb_burst_seq #(
    parameter int BB = 2
) (
    input  logic          order_ilv,
    input  logic [BB-1:0] start_lo,
    input  logic [BB-1:0] beat,
    output logic [BB-1:0] addr_lo
);
    always_comb begin
        if (order_ilv) addr_lo = start_lo ^ beat;
        else           addr_lo = start_lo + beat;
    end
endmodule

// File: rtl/srb_lane_array.sv
module srb_lane_array #(
    parameter int AW    = 6,
    parameter int LANES = 4,
    parameter int LB    = 9
) (
    input  logic                clk,
    input  logic                wr_en,
    input  logic [LANES-1:0]    lane_en,
    input  logic [AW-1:0]       addr,
    input  logic [LANES*LB-1:0] wdata,
    output logic [LANES*LB-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LB-1:0] mem_q [DEPTH];
        always_ff @(posedge clk) begin
            if (wr_en && lane_en[g]) mem_q[addr] <= wdata[g*LB +: LB];
        end
        assign rdata[g*LB +: LB] = mem_q[addr];
    end
endmodule

// File: rtl/srb_sram.sv
module srb_sram
    import srb_pkg::*;
#(
    parameter int AW    = 6,
    parameter int LANES = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sleep,
    input  logic                       strobe_n,
    input  logic                       sel_n,
    input  logic                       adv_n,
    input  logic                       order_ilv,
    input  logic [LANES-1:0]           lane_we_n,
    input  logic [AW-1:0]              addr,
    input  logic [LANES*LANE_BITS-1:0] wdata,
    output logic [LANES*LANE_BITS-1:0] rdata,
    output logic                       rvalid
);
    localparam int W = LANES * LANE_BITS;

    typedef struct packed {
        logic                 active;
        logic [AW-1:0]        base;
        logic [BEAT_BITS-1:0] beat;
        logic                 rvalid;
        logic [W-1:0]         rdata;
    } state_t;

    state_t st_d, st_q;

    logic                 load_s, desel_s, step_s, access_s, write_s;
    logic [BEAT_BITS-1:0] beat_nx, lo_nx;
    logic [AW-1:0]        acc_addr;
    logic [W-1:0]         arr_rd;

    assign load_s   = !strobe_n && !sel_n;
    assign desel_s  = !strobe_n && sel_n;
    assign step_s   = strobe_n && st_q.active && !adv_n;
    assign access_s = load_s || step_s;
    assign write_s  = access_s && !(&lane_we_n);
    assign beat_nx  = st_q.beat + 1'b1;

    srb_burst_seq #(.BB(BEAT_BITS)) seq_i (
        .order_ilv (order_ilv),
        .start_lo  (st_q.base[BEAT_BITS-1:0]),
        .beat      (beat_nx),
        .addr_lo   (lo_nx)
    );

    assign acc_addr = load_s ? addr : {st_q.base[AW-1:BEAT_BITS], lo_nx};

    srb_lane_array #(.AW(AW), .LANES(LANES), .LB(LANE_BITS)) arr_i (
        .clk     (clk),
        .wr_en   (write_s && !sleep),
        .lane_en (~lane_we_n),
        .addr    (acc_addr),
        .wdata   (wdata),
        .rdata   (arr_rd)
    );

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = 1'b0;
        st_d.rdata  = '0;
        if (load_s) begin
            st_d.active = 1'b1;
            st_d.base   = addr;
            st_d.beat   = '0;
        end else if (desel_s) begin
            st_d.active = 1'b0;
        end else if (step_s) begin
            st_d.beat = beat_nx;
        end
        if (access_s && !write_s) begin
            st_d.rvalid = 1'b1;
            st_d.rdata  = arr_rd;
        end
    end

    always_ff @(posedge clk or negedge rst_n or posedge sleep) begin
        if (!rst_n)     st_q <= '0;
        else if (sleep) st_q <= '0;
        else            st_q <= st_d;
    end

    assign rdata  = st_q.rdata;
    assign rvalid = st_q.rvalid;

    AST_READ_VALID: assert property (@(posedge clk) disable iff (!rst_n || sleep)
        (!strobe_n && !sel_n && (&lane_we_n)) |=> rvalid); // R2
    AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n || sleep)
        (!strobe_n && sel_n) |=> !rvalid); // R3
    AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n || sleep)
        (access_s && !(&lane_we_n)) |=> !rvalid); // R7
    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n || sleep)
        (strobe_n && adv_n) |=> (!rvalid && $stable(st_q.beat))); // R8
    AST_BEAT_WRAP: assert property (@(posedge clk) disable iff (!rst_n || sleep)
        (step_s && st_q.beat == 2'd3) |=> (st_q.beat == 2'd0)); // R9
    AST_SLEEP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> (!rvalid && rdata == '0 && !st_q.active)); // R6
endmodule

// File: tb/srb_sram_tb.sv
`timescale 1ns/1ps
module srb_sram_tb_top;
    localparam int AW = 6;
    localparam int L  = 4;
    localparam int W  = 9 * L;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sleep = 1'b0;
    logic strobe_n = 1'b1, sel_n = 1'b1, adv_n = 1'b1, order_ilv = 1'b0;
    logic [L-1:0]  lane_we_n = '1;
    logic [AW-1:0] addr = '0;
    logic [W-1:0]  wdata = '0;
    logic [W-1:0]  rdata;
    logic          rvalid;

    int checks = 0;
    int errors = 0;

    logic [W-1:0]  m_mem [DEPTH];
    bit            m_active = 0;
    logic [AW-1:0] m_base = '0;
    int            m_beat = 0;
    bit            e_valid = 0;
    logic [W-1:0]  e_data = '0;

    always #2 clk = ~clk;

    srb_sram #(.AW(AW), .LANES(L)) dut_i (
        .clk(clk), .rst_n(rst_n), .sleep(sleep), .strobe_n(strobe_n),
        .sel_n(sel_n), .adv_n(adv_n), .order_ilv(order_ilv),
        .lane_we_n(lane_we_n), .addr(addr), .wdata(wdata),
        .rdata(rdata), .rvalid(rvalid)
    );

    task automatic compare(string tag);
        checks++;
        if (rvalid !== e_valid || rdata !== e_data) begin
            errors++;
            $display("FAIL %s: rvalid=%0b rdata=%h expected rvalid=%0b rdata=%h",
                     tag, rvalid, rdata, e_valid, e_data);
        end
    endtask

    function automatic logic [AW-1:0] beat_addr(int k);
        int lo;
        if (order_ilv) lo = m_base[1:0] ^ k;
        else           lo = (m_base[1:0] + k) % 4;
        return {m_base[AW-1:2], 2'(lo)};
    endfunction

    task automatic model();
        bit acc = 0;
        logic [AW-1:0] a = '0;
        e_valid = 0;
        e_data  = '0;
        if (sleep) begin
            m_active = 0;
            return;
        end
        if (!strobe_n && !sel_n) begin
            m_active = 1; m_base = addr; m_beat = 0; acc = 1; a = addr;
        end else if (!strobe_n && sel_n) begin
            m_active = 0;
        end else if (m_active && !adv_n) begin
            m_beat = (m_beat + 1) % 4; acc = 1; a = beat_addr(m_beat);
        end
        if (acc) begin
            if (lane_we_n != '1) begin
                for (int i = 0; i < L; i++)
                    if (!lane_we_n[i]) m_mem[a][i*9 +: 9] = wdata[i*9 +: 9];
            end else begin
                e_valid = 1;
                e_data  = m_mem[a];
            end
        end
    endtask

    task automatic drive(bit sn, bit sl, bit av, logic [L-1:0] we,
                         logic [AW-1:0] a, logic [W-1:0] d, string tag);
        @(negedge clk);
        strobe_n = sn; sel_n = sl; adv_n = av; lane_we_n = we; addr = a; wdata = d;
        @(posedge clk);
        model();
        #1 compare(tag);
    endtask

    task automatic ld_rd(logic [AW-1:0] a, string tag);
        drive(0, 0, 1, '1, a, '0, tag);
    endtask
    task automatic ld_wr(logic [AW-1:0] a, logic [W-1:0] d, string tag);
        drive(0, 0, 1, '0, a, d, tag);
    endtask
    task automatic adv_rd(string tag);
        drive(1, 1, 0, '1, '0, '0, tag);
    endtask
    task automatic adv_wr(logic [L-1:0] we, logic [W-1:0] d, string tag);
        drive(1, 1, 0, we, '0, d, tag);
    endtask
    task automatic desel(string tag);
        drive(0, 1, 1, '1, '0, '0, tag);
    endtask

    function automatic logic [W-1:0] rnd();
        return {$urandom(), $urandom()};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 compare("R10 reset");
        @(negedge clk);
        rst_n = 1'b1;
        adv_rd("R10 deselected after reset");

        // fill the array
        for (int a = 0; a < DEPTH; a++) ld_wr(6'(a), rnd(), "R7 fill");

        // linear burst from low bits 2
        order_ilv = 0;
        desel("R3");
        ld_wr(6'd6, rnd(), "R7 linear write");
        for (int k = 1; k < 4; k++) adv_wr('0, rnd(), "R4 linear write beat");
        ld_rd(6'd6, "R2 read start");
        for (int k = 1; k < 6; k++) adv_rd("R4 R9 linear read/wrap");

        // interleaved burst from low bits 1
        desel("R3");
        order_ilv = 1;
        ld_wr(6'd9, rnd(), "R7 ilv write");
        for (int k = 1; k < 4; k++) adv_wr('0, rnd(), "R5 ilv write beat");
        ld_rd(6'd9, "R2");
        for (int k = 1; k < 6; k++) adv_rd("R5 R9 ilv read/wrap");

        // partial lane writes
        ld_wr(6'd9, rnd(), "R7");
        drive(0, 0, 1, 4'b1010, 6'd9, rnd(), "R7 lanes 0,2");
        drive(0, 0, 1, 4'b0111, 6'd9, rnd(), "R7 lane 3 parity");
        ld_rd(6'd9, "R7 readback");

        // hold then advance
        ld_rd(6'd20, "R8");
        drive(1, 1, 1, '1, '0, '0, "R8 hold");
        drive(1, 1, 1, '0, '0, rnd(), "R8 hold with write ignored");
        adv_rd("R8 resume");
        adv_rd("R8");

        // abort mid burst
        ld_rd(6'd33, "R1");
        adv_rd("R1");
        ld_rd(6'd50, "R1 abort");
        adv_rd("R1 new burst");

        // deselect then advances ignored
        desel("R3");
        adv_rd("R3 advance ignored");
        adv_wr('0, rnd(), "R3 write ignored");
        ld_rd(6'd50, "R3 contents kept");

        // sleep mid burst
        ld_rd(6'd12, "R6");
        @(negedge clk);
        strobe_n = 1; adv_n = 0; lane_we_n = '1;
        sleep = 1'b1;
        m_active = 0; e_valid = 0; e_data = '0;
        #1 compare("R6 async clear");
        drive(0, 0, 1, '0, 6'd12, rnd(), "R6 write ignored");
        drive(1, 1, 0, '1, '0, '0, "R6 advance ignored");
        @(negedge clk);
        sleep = 1'b0;
        adv_rd("R6 deselected after release");
        ld_rd(6'd12, "R6 contents kept");

        // random traffic
        for (int seg = 0; seg < 6; seg++) begin
            desel("R3");
            order_ilv = seg[0];
            for (int n = 0; n < 150; n++) begin
                bit sn = ($urandom % 4) != 0;
                bit sl = ($urandom % 5) == 0;
                bit av = ($urandom % 10) < 3;
                logic [L-1:0] we = ($urandom % 2) ? '1 : L'($urandom);
                drive(sn, sl, av, we, AW'($urandom), rnd(), "R1 R2 R4 R5 R7 R8 random");
            end
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule